// File: doc/BRIEF.md
# Timed Event-to-Telegram Dispatcher

This block sits between a timing-event source and a serial telegram transmitter. Each incoming event carries a 64-bit identifier and a 64-bit deadline, both in nanoseconds. The block also receives a free-running nanosecond time count. Identifiers that follow one fixed pattern carry a 16-bit bus telegram. The block queues those telegrams with their deadlines in arrival order. All other events are discarded.

The head telegram is offered to the transmitter once the current time has reached its deadline. The offer is a valid/ready handshake. Each accepted telegram opens a transmission slot of 25 µs: 20 µs on the wire plus a 5 µs gap. The next telegram is held back until that slot has elapsed, even if its own deadline came earlier. Two counters record the failures: events dropped because the queue was full, and telegrams sent noticeably after their deadline.

Top module: `tg_dispatch`

## Requirements
- R1: An event is accepted only when ev_id[63:32] is all ones and ev_id[31:16] is all zeros. Any other event adds no telegram and changes no counter.
- R2: A telegram is presented on tg_data as ev_id[15:0] exactly. The low byte is the event number (0 to 255) and the high byte passes through unchanged.
- R3: tg_valid is never high while now_ns is below the head entry's deadline, compared as unsigned numbers. When the slot is free and the transmitter is ready, the telegram goes out in the first cycle where now_ns ≥ deadline.
- R4: Telegrams leave in the order their events arrived.
- R5: After a handshake at time t, the next handshake happens no earlier than now_ns ≥ t + SLOT_NS (25000 ns). A held telegram goes out in the first cycle that satisfies this bound.
- R6: While tg_valid is high and tg_ready is low, tg_valid stays high and tg_data stays unchanged.
- R7: The queue holds DEPTH (4) entries. A qualifying event that arrives while the queue is full is dropped and increments overflow_count by one.
- R8: late_count increments on each handshake where now_ns ≥ deadline + LATE_NS (1000 ns). A telegram sent within that margin does not count.
- R9: After reset the queue is empty, tg_valid is low, both counters are zero, and no slot restriction applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event strobe, one cycle per event |
| ev_id | input | 64 | Event identifier |
| ev_deadline | input | TW | Time at which the telegram is due, in ns |
| now_ns | input | TW | Current time in ns, monotonically increasing |
| tg_valid | output | 1 | Head telegram is due and may be taken |
| tg_ready | input | 1 | Transmitter accepts the telegram |
| tg_data | output | 16 | Telegram payload |
| late_count | output | CW | Number of telegrams sent late |
| overflow_count | output | CW | Number of events lost to a full queue |

## Verification
The bench probes the identifier filter with one near-miss in the upper word and one in the middle field. A loose filter would send a stray telegram. The bench watches tg_valid right up to a future deadline and then measures the release time. This catches a signed or off-by-one comparison, which would release early or a cycle late. Three telegrams that are already overdue, plus one that is due during the previous slot, expose any missing or miscounted 25 µs spacing, because the gaps between sends are measured. The bench also fills the queue while the transmitter is stalled. A design that overwrote entries, or lost the drop count, would deliver the wrong payloads or report the wrong overflow total.

// File: rtl/tg_dispatch.sv
module tg_dispatch #(
  parameter int DEPTH   = 4,
  parameter int TW      = 64,
  parameter int SLOT_NS = 25000,
  parameter int LATE_NS = 1000,
  parameter int CW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [63:0]   ev_id,
  input  logic [TW-1:0] ev_deadline,
  input  logic [TW-1:0] now_ns,
  output logic          tg_valid,
  input  logic          tg_ready,
  output logic [15:0]   tg_data,
  output logic [CW-1:0] late_count,
  output logic [CW-1:0] overflow_count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TW-1:0] dl_mem [DEPTH];
  logic [15:0]   pl_mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;
  logic [TW-1:0] slot_end;

  wire id_ok = (&ev_id[63:32]) && (ev_id[31:16] == 16'h0);
  wire full  = (fill == (AW+1)'(DEPTH));
  wire push  = ev_valid && id_ok && !full;
  wire drop  = ev_valid && id_ok && full;

  wire [TW-1:0] head_dl = dl_mem[rd_ptr];
  assign tg_valid = (fill != '0) && (now_ns >= head_dl) && (now_ns >= slot_end);
  assign tg_data  = pl_mem[rd_ptr];
  wire pop = tg_valid && tg_ready;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      dl_mem[wr_ptr] <= ev_deadline;
      pl_mem[wr_ptr] <= ev_id[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr         <= '0;
      rd_ptr         <= '0;
      fill           <= '0;
      slot_end       <= '0;
      late_count     <= '0;
      overflow_count <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop) begin
        rd_ptr   <= nxt(rd_ptr);
        slot_end <= now_ns + TW'(SLOT_NS);
        if (now_ns >= head_dl + TW'(LATE_NS)) late_count <= late_count + 1'b1;
      end
      fill <= fill + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      if (drop) overflow_count <= overflow_count + 1'b1;
    end
  end
endmodule

module tg_dispatch_chk #(
  parameter int TW      = 64,
  parameter int SLOT_NS = 25000,
  parameter int CW      = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic [TW-1:0] now_ns,
  input logic          tg_valid,
  input logic          tg_ready,
  input logic [15:0]   tg_data,
  input logic [CW-1:0] late_count,
  input logic [CW-1:0] overflow_count
);
  logic [TW-1:0] last_t;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_t <= '0;
      seen   <= 1'b0;
    end else if (tg_valid && tg_ready) begin
      last_t <= now_ns;
      seen   <= 1'b1;
    end
  end

  assert_slot_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_valid && tg_ready && seen) |-> (now_ns >= last_t + TW'(SLOT_NS)));

  assert_hold_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_valid && !tg_ready) |=> (tg_valid && $stable(tg_data)));

  assert_overflow_only_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(overflow_count));

  assert_late_only_on_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tg_valid && tg_ready) |=> $stable(late_count));

  assert_reset_state_R9: assert property (@(posedge clk)
    !rst_n |=> (!tg_valid && late_count == '0 && overflow_count == '0));
endmodule

bind tg_dispatch tg_dispatch_chk #(.TW(TW), .SLOT_NS(SLOT_NS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .now_ns(now_ns),
  .tg_valid(tg_valid), .tg_ready(tg_ready), .tg_data(tg_data),
  .late_count(late_count), .overflow_count(overflow_count)
);

// File: tb/tg_dispatch_bench.sv
module tg_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [63:0] ev_id = '0;
  logic [63:0] ev_deadline = '0;
  logic [63:0] now_ns = '0;
  logic        tg_ready = 1'b1;
  logic        tg_valid;
  logic [15:0] tg_data;
  logic [15:0] late_count, overflow_count;

  int n_chk = 0, n_err = 0, log_n = 0;
  bit done = 1'b0;
  logic [15:0] log_d [64];
  logic [63:0] log_t [64];

  tg_dispatch u_tg_dispatch (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_id(ev_id),
    .ev_deadline(ev_deadline), .now_ns(now_ns), .tg_valid(tg_valid),
    .tg_ready(tg_ready), .tg_data(tg_data), .late_count(late_count),
    .overflow_count(overflow_count)
  );

  always #4 clk = ~clk;
  always @(posedge clk) now_ns <= now_ns + 64'd8;

  always @(posedge clk) begin
    if (rst_n && tg_valid && tg_ready && log_n < 64) begin
      log_d[log_n] <= tg_data;
      log_t[log_n] <= now_ns;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] good_id(input logic [15:0] p);
    return {32'hFFFF_FFFF, 16'h0000, p};
  endfunction

  task automatic send_ev(input logic [63:0] id, input logic [63:0] dl);
    @(negedge clk);
    ev_valid = 1'b1; ev_id = id; ev_deadline = dl;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_sent(input int n);
    for (int i = 0; i < 20000 && log_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_clear();
    repeat (3200) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!tg_valid, "R9", "tg_valid after reset", tg_valid, 0);
    chk(late_count == 0, "R9", "late_count after reset", late_count, 0);
    chk(overflow_count == 0, "R9", "overflow_count after reset", overflow_count, 0);
  endtask

  task automatic t_filter();
    int base = log_n;
    logic [15:0] lb = late_count, ob = overflow_count;
    send_ev({32'hFFFF_FFFE, 16'h0000, 16'h1234}, 64'd0);
    send_ev({32'hFFFF_FFFF, 16'h0001, 16'h1234}, 64'd0);
    repeat (10) @(negedge clk);
    chk(!tg_valid, "R1", "tg_valid after bad ids", tg_valid, 0);
    chk(log_n == base, "R1", "sends after bad ids", log_n - base, 0);
    chk(overflow_count == ob && late_count == lb, "R1", "counters after bad ids",
        {overflow_count, late_count}, {ob, lb});
    send_ev(good_id(16'hA55A), 64'd0);
    wait_sent(base + 1);
    repeat (5) @(negedge clk);
    chk(log_n == base + 1, "R1", "only qualifying event sent", log_n - base, 1);
    chk(log_d[base] == 16'hA55A, "R2", "payload", log_d[base], 16'hA55A);
    chk(late_count == lb + 1, "R8", "overdue telegram counted late", late_count, lb + 1);
  endtask

  task automatic t_ontime();
    int base = log_n;
    logic [15:0] lb = late_count;
    logic [63:0] dl;
    bit early = 1'b0;
    wait_clear();
    dl = now_ns + 64'd4000;
    send_ev(good_id(16'h0042), dl);
    for (int i = 0; i < 2000 && log_n == base; i++) begin
      @(negedge clk);
      if (tg_valid && now_ns < dl) early = 1'b1;
    end
    chk(!early, "R3", "offered before deadline", early, 0);
    chk(log_n == base + 1 && log_t[base] >= dl && log_t[base] < dl + 8, "R3",
        "send time", log_t[base], dl);
    chk(late_count == lb, "R8", "prompt telegram not late", late_count, lb);
  endtask

  task automatic t_order_spacing();
    int base = log_n;
    logic [15:0] lb = late_count;
    wait_clear();
    send_ev(good_id(16'h0101), 64'd0);
    send_ev(good_id(16'h0202), 64'd0);
    send_ev(good_id(16'h0303), 64'd0);
    wait_sent(base + 3);
    for (int k = 0; k < 3; k++)
      chk(log_d[base+k] == 16'h0101 * (k + 1), "R4", "arrival order",
          log_d[base+k], 16'h0101 * (k + 1));
    for (int k = 0; k < 2; k++)
      chk(log_t[base+k+1] - log_t[base+k] >= 25000 &&
          log_t[base+k+1] - log_t[base+k] < 25008, "R5", "slot gap",
          log_t[base+k+1] - log_t[base+k], 25000);
    chk(late_count == lb + 3, "R8", "three overdue sends", late_count, lb + 3);
  endtask

  task automatic t_slot_hold();
    int base = log_n;
    logic [15:0] lb = late_count;
    logic [63:0] dl;
    wait_clear();
    dl = now_ns + 64'd2000;
    send_ev(good_id(16'h0A0A), dl);
    send_ev(good_id(16'h0B0B), dl + 64'd10000);
    wait_sent(base + 2);
    chk(log_t[base] >= dl && log_t[base] < dl + 8, "R3", "first send on time", log_t[base], dl);
    chk(log_t[base+1] >= log_t[base] + 25000 && log_t[base+1] < log_t[base] + 25008,
        "R5", "held to slot end", log_t[base+1] - log_t[base], 25000);
    chk(late_count == lb + 1, "R8", "held telegram counted late", late_count, lb + 1);
  endtask

  task automatic t_overflow();
    int base = log_n;
    logic [15:0] ob = overflow_count;
    bit moved = 1'b0;
    wait_clear();
    tg_ready = 1'b0;
    for (int k = 0; k < 6; k++) send_ev(good_id(16'h0010 + 16'(k)), 64'd0);
    @(negedge clk);
    chk(overflow_count == ob + 2, "R7", "overflow count", overflow_count, ob + 2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!tg_valid || tg_data != 16'h0010) moved = 1'b1;
    end
    chk(!moved, "R6", "offer held under backpressure", tg_data, 16'h0010);
    tg_ready = 1'b1;
    wait_sent(base + 4);
    repeat (3300) @(negedge clk);
    chk(log_n == base + 4, "R7", "sent after overflow", log_n - base, 4);
    for (int k = 0; k < 4; k++)
      chk(log_d[base+k] == 16'h0010 + 16'(k), "R7", "kept entries",
          log_d[base+k], 16'h0010 + k);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    repeat (200) @(negedge clk);
    t_filter();
    t_ontime();
    t_order_spacing();
    t_slot_hold();
    t_overflow();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule